// File: doc/BRIEF.md
# Global Status Byte Keeper

This block holds the eight-bit status byte that a serial slave returns first in every frame. It collects level fault inputs from the device: fail-safe mode, thermal shutdown or overload, temperature pre-warning, two device-specific faults and a set of extra failure lines. From the serial engine it takes two one-cycle pulses, one for a valid frame and one for a broken frame. The faults that must survive until software has seen them are latched. They are released by a read-and-clear strobe that names the status address.

Bit 5 is active low. It reads 0 after reset and after a communication error, and a valid frame sets it to 1. Bit 7 summarises every failure, including a low bit 5. It also drives a shared open-drain failure line, modelled as an output enable next to a data value that is always 0.

All pins are plain level or pulse controls. No data stream crosses this block, so no valid/ready handshake applies.

Top module: `global_status_reg`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) makes status_o read 8'h80 from the next cycle: bits 6..0 are 0, and bit 7 is 1 because bit 5 is low.
- R2: Bit 5 becomes 1 in the cycle after a frame_ok_i pulse and 0 in the cycle after a frame_err_i pulse. When both pulse in the same cycle, the error wins.
- R3: Bit 6 (communication error) is set in the cycle after a frame_err_i pulse. It stays set until a matching read-and-clear.
- R4: Each latched fault bit is set by its source and stays set after the source drops: bit 4 from tsd_i, bit 3 from prewarn_i, bit 2 from dev_fault_i[1], bit 1 from dev_fault_i[0].
- R5: A rdclr_i pulse with rdclr_addr_i equal to STATUS_ADDR (default 6'h00) clears bits 6, 4, 3, 2 and 1 in the next cycle. A bit whose source is active in that same cycle stays 1.
- R6: A rdclr_i pulse with any other address changes no status bit.
- R7: Bit 0 copies fail_safe_i one cycle later and is not latched.
- R8: Bit 7 is the OR of bits 6, 4, 3, 2, 1 and 0, of the inverse of bit 5, and of any extra_fault_i line registered one cycle earlier. Extra faults are not latched.
- R9: fail_oe_o equals status bit 7 in every cycle, and fail_do_o is always 0.
- R10: When HAS_FAILSAFE, HAS_TSD or HAS_PREWARN is 0, the matching bit (0, 4 or 3) always reads 0, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fail_safe_i | input | 1 | Device is in fail-safe mode (level) |
| tsd_i | input | 1 | Thermal shutdown or overload (level) |
| prewarn_i | input | 1 | Temperature pre-warning (level) |
| dev_fault_i | input | 2 | Device-specific faults: [1] feeds bit 2, [0] feeds bit 1 |
| extra_fault_i | input | NUM_EXTRA | Further device failures that only feed the summary bit |
| frame_ok_i | input | 1 | One-cycle pulse: a frame completed correctly |
| frame_err_i | input | 1 | One-cycle pulse: a frame had a bad clock count or another fault |
| rdclr_i | input | 1 | One-cycle read-and-clear strobe |
| rdclr_addr_i | input | ADDR_W | Address carried by the read-and-clear strobe |
| status_o | output | 8 | Status byte |
| fail_oe_o | output | 1 | Failure line enable: 1 pulls the shared line low |
| fail_do_o | output | 1 | Failure line data value, fixed at 0 |

## Verification
A wrong latch or clear state shows up in status_o one cycle after the stimulus, and the summary bit and fail_oe_o show it in the same cycle. A lost latch in a sticky bit is found on the first idle cycle after its source drops. A clear that fires too widely is found on the cycle after a strobe to a foreign address, or after a strobe while a source is still active. An inverted bit 5 shows at once after reset, because the summary bit then reads 0 instead of 1.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  localparam int unsigned GSR_W      = 8;
  localparam int unsigned NUM_STICKY = 5;
  localparam int unsigned NUM_FAULT  = 7;
  localparam int unsigned B_GEF  = 7;
  localparam int unsigned B_COMM = 6;
  localparam int unsigned B_NRST = 5;
  localparam int unsigned B_TSD  = 4;
  localparam int unsigned B_PREW = 3;
  localparam int unsigned B_DEV2 = 2;
  localparam int unsigned B_DEV1 = 1;
  localparam int unsigned B_FS   = 0;
  typedef logic [GSR_W-1:0] gsr_byte_t;
endpackage

// File: rtl/gsr_sticky_bit.sv
module gsr_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set beats clear: an active source keeps the bit
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/gsr_reset_flag.sv
module gsr_reset_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ok_i,
  input  logic err_i,
  output logic q_o
);
  // active-low health flag: low after reset or error, high after a good frame
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (err_i) q_o <= 1'b0;
    else if (ok_i)  q_o <= 1'b1;
  end
endmodule

// File: rtl/gsr_error_summary.sv
module gsr_error_summary #(
  parameter int unsigned NUM_FAULT = 7,
  parameter int unsigned NRST_IDX  = 5
) (
  input  logic [NUM_FAULT-1:0] fault_bits_i,
  input  logic                 extra_i,
  output logic                 gef_o,
  output logic                 oe_o,
  output logic                 do_o
);
  logic [NUM_FAULT-1:0] active_fail;

  always_comb begin
    active_fail           = fault_bits_i;
    active_fail[NRST_IDX] = ~fault_bits_i[NRST_IDX];
  end

  assign gef_o = (|active_fail) | extra_i;
  assign oe_o  = gef_o;
  assign do_o  = 1'b0;
endmodule

// File: rtl/global_status_reg.sv
module global_status_reg
  import gsr_pkg::*;
#(
  parameter int unsigned ADDR_W       = 6,
  parameter int unsigned STATUS_ADDR  = 0,
  parameter int unsigned NUM_EXTRA    = 2,
  parameter bit          HAS_FAILSAFE = 1'b1,
  parameter bit          HAS_TSD      = 1'b1,
  parameter bit          HAS_PREWARN  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fail_safe_i,
  input  logic                 tsd_i,
  input  logic                 prewarn_i,
  input  logic [1:0]           dev_fault_i,
  input  logic [NUM_EXTRA-1:0] extra_fault_i,
  input  logic                 frame_ok_i,
  input  logic                 frame_err_i,
  input  logic                 rdclr_i,
  input  logic [ADDR_W-1:0]    rdclr_addr_i,
  output logic [7:0]           status_o,
  output logic                 fail_oe_o,
  output logic                 fail_do_o
);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(STATUS_ADDR);
  localparam int unsigned STICKY_POS [NUM_STICKY] = '{B_DEV1, B_DEV2, B_PREW, B_TSD, B_COMM};

  logic                  clr_hit;
  logic [NUM_STICKY-1:0] sticky_src;
  logic [NUM_STICKY-1:0] sticky_q;
  logic                  nrst_q;
  logic                  fs_q;
  logic                  extra_q;
  logic                  gef;
  gsr_byte_t             byte_q;

  assign clr_hit = rdclr_i && (rdclr_addr_i == CLR_ADDR);

  assign sticky_src = {frame_err_i,
                       tsd_i & HAS_TSD,
                       prewarn_i & HAS_PREWARN,
                       dev_fault_i[1],
                       dev_fault_i[0]};

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    gsr_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (sticky_src[i]),
      .clr_i (clr_hit),
      .q_o   (sticky_q[i])
    );
  end

  gsr_reset_flag u_nrst (
    .clk   (clk),
    .rst_n (rst_n),
    .ok_i  (frame_ok_i),
    .err_i (frame_err_i),
    .q_o   (nrst_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q    <= 1'b0;
      extra_q <= 1'b0;
    end else begin
      fs_q    <= fail_safe_i & HAS_FAILSAFE;
      extra_q <= |extra_fault_i;
    end
  end

  always_comb begin
    byte_q         = '0;
    byte_q[B_NRST] = nrst_q;
    byte_q[B_FS]   = fs_q;
    for (int k = 0; k < NUM_STICKY; k++) byte_q[STICKY_POS[k]] = sticky_q[k];
    byte_q[B_GEF]  = gef;
  end

  gsr_error_summary #(
    .NUM_FAULT (NUM_FAULT),
    .NRST_IDX  (B_NRST)
  ) u_sum (
    .fault_bits_i ({sticky_q[4], nrst_q, sticky_q[3], sticky_q[2],
                    sticky_q[1], sticky_q[0], fs_q}),
    .extra_i      (extra_q),
    .gef_o        (gef),
    .oe_o         (fail_oe_o),
    .do_o         (fail_do_o)
  );

  assign status_o = byte_q;
endmodule

// File: rtl/gsr_chk.sv
module gsr_chk #(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned STATUS_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_ok_i,
  input logic              frame_err_i,
  input logic              rdclr_i,
  input logic [ADDR_W-1:0] rdclr_addr_i,
  input logic [7:0]        status_o,
  input logic              fail_oe_o
);
  logic hit;
  assign hit = rdclr_i && (rdclr_addr_i == ADDR_W'(STATUS_ADDR));

  // R2
  good_frame_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok_i && !frame_err_i) |=> status_o[5]);

  // R2
  bad_frame_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_i |=> !status_o[5]);

  // R3
  comm_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_i |=> status_o[6]);

  // R5
  comm_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[6] && !hit) |=> status_o[6]);

  // R9
  line_pulls_on_comm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6] |-> fail_oe_o);

  // R8
  line_pulls_on_nrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[5] |-> fail_oe_o);
endmodule

bind global_status_reg gsr_chk #(
  .ADDR_W      (ADDR_W),
  .STATUS_ADDR (STATUS_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_ok_i   (frame_ok_i),
  .frame_err_i  (frame_err_i),
  .rdclr_i      (rdclr_i),
  .rdclr_addr_i (rdclr_addr_i),
  .status_o     (status_o),
  .fail_oe_o    (fail_oe_o)
);

// File: tb/global_status_reg_bench.sv
module global_status_reg_bench;
  typedef struct {
    logic [7:0] st;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fs = 0, tsd = 0, pw = 0, ok = 0, err = 0, rc = 0;
  logic [1:0] dv = 0, ex = 0;
  logic [5:0] ad = 0;
  logic [7:0] st, st_b;
  logic       oe, dout, oe_b, dout_b;

  int checks = 0, errors = 0;
  exp_t q[$];

  // reference model state
  bit m6, m5, m4, m3, m2, m1, m0, mx;

  always #5 clk = ~clk;

  global_status_reg u_global_status_reg (
    .clk(clk), .rst_n(rst_n), .fail_safe_i(fs), .tsd_i(tsd), .prewarn_i(pw),
    .dev_fault_i(dv), .extra_fault_i(ex), .frame_ok_i(ok), .frame_err_i(err),
    .rdclr_i(rc), .rdclr_addr_i(ad), .status_o(st), .fail_oe_o(oe), .fail_do_o(dout));

  global_status_reg #(.HAS_FAILSAFE(1'b0), .HAS_TSD(1'b0), .HAS_PREWARN(1'b0)) u_bare (
    .clk(clk), .rst_n(rst_n), .fail_safe_i(fs), .tsd_i(tsd), .prewarn_i(pw),
    .dev_fault_i(dv), .extra_fault_i(ex), .frame_ok_i(ok), .frame_err_i(err),
    .rdclr_i(rc), .rdclr_addr_i(ad), .status_o(st_b), .fail_oe_o(oe_b), .fail_do_o(dout_b));

  task automatic drive(input bit r, input bit f_s, input bit t, input bit p,
                       input logic [1:0] d, input logic [1:0] x,
                       input bit k, input bit e, input bit c,
                       input logic [5:0] a, input string tag);
    exp_t it;
    bit hit;
    @(negedge clk);
    rst_n = ~r; fs = f_s; tsd = t; pw = p; dv = d; ex = x;
    ok = k; err = e; rc = c; ad = a;
    hit = c && (a == 6'h00);
    if (r) begin
      {m6, m5, m4, m3, m2, m1, m0, mx} = '0;
    end else begin
      m6 = e | (m6 & ~hit);
      m5 = e ? 1'b0 : (k ? 1'b1 : m5);
      m4 = t | (m4 & ~hit);
      m3 = p | (m3 & ~hit);
      m2 = d[1] | (m2 & ~hit);
      m1 = d[0] | (m1 & ~hit);
      m0 = f_s;
      mx = |x;
    end
    it.st  = {m6 | ~m5 | m4 | m3 | m2 | m1 | m0 | mx, m6, m5, m4, m3, m2, m1, m0};
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compare one expected item per cycle after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (st !== e.st) begin
          errors++;
          $display("FAIL %s status actual %h expected %h", e.tag, st, e.st);
        end
        checks++;
        if (oe !== e.st[7] || dout !== 1'b0) begin
          errors++;
          $display("FAIL R9 (%s) oe/do actual %b%b expected %b0", e.tag, oe, dout, e.st[7]);
        end
      end
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    drive(1, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0, 6'h00, "R1 reset");
    drive(1, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0, 6'h00, "R1 reset");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0, 6'h00, "R1 after reset");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 1, 0, 0, 6'h00, "R2 good frame");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0, 6'h00, "R2 idle");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 0, 1, 0, 6'h00, "R3 bad frame");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0, 6'h00, "R3 sticky");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 1, 0, 0, 6'h00, "R2 recover");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 1, 6'h08, "R6 foreign addr");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 1, 6'h00, "R5 clear");
    drive(0, 1, 1, 1, 2'b00, 2'b00, 0, 0, 0, 6'h00, "R4 tsd/prewarn");
    @(posedge clk);
    #3;
    checks++;
    if ((st_b & 8'h19) !== 8'h00) begin
      errors++;
      $display("FAIL R10 bare bits actual %h expected 00", st_b & 8'h19);
    end
    drive(0, 0, 0, 0, 2'b11, 2'b00, 0, 0, 0, 6'h00, "R4 dev faults");
    drive(0, 0, 0, 0, 2'b01, 2'b00, 0, 0, 1, 6'h00, "R5 active source kept");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0, 6'h00, "R4 hold");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 1, 6'h00, "R5 clear rest");
    drive(0, 1, 0, 0, 2'b00, 2'b00, 0, 0, 0, 6'h00, "R7 fail-safe on");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0, 6'h00, "R7 fail-safe off");
    drive(0, 0, 0, 0, 2'b00, 2'b10, 0, 0, 0, 6'h00, "R8 extra fault");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0, 6'h00, "R8 extra gone");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 1, 1, 0, 6'h00, "R2 error wins");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 0, 1, 1, 6'h00, "R5 set beats clear");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 1, 0, 1, 6'h00, "R5 clear comm");
    drive(0, 0, 1, 0, 2'b00, 2'b00, 0, 0, 0, 6'h00, "R4 tsd again");
    drive(1, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0, 6'h00, "R1 mid-run reset");
    drive(0, 0, 0, 0, 2'b00, 2'b00, 0, 0, 0, 6'h00, "R1 after reset");
    @(posedge clk);
    #4;
    @(posedge clk);
    #4;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule